// File: doc/BRIEF.md
# Eight-Way Chip-Select Address Decoder

This block turns a 32-bit system-bus address into at most one of eight external chip selects. Every bank owns one 32-bit window register. Each register holds a bank enable, a base address at 128 KiB granularity, and a per-bit compare field that sets how many upper address bits take part in the match. Software programs the windows through a small register write and read port. Each address qualified by a valid strobe produces a registered one-hot select on the next clock.

Two boot-time behaviours are built in. A swap strap is captured while reset is held, and it exchanges the first two physical selects. A window register of bank 0 or bank 1 that reads all zeros makes that bank capture every access, whatever its enable bit says. Because reset clears every register, the block comes out of reset routing all traffic to the boot bank.

Top module: `cs_bank_decoder`

## Requirements
- R1: Bank n's window register sits at register offset 0x100 + 0x10*n (n = 0..7). A write there is read back unchanged at the same offset, and every register is zero after reset.
- R2: A write to any offset that is not one of the eight window registers changes no register. A read of such an offset returns zero.
- R3: Window bit 0 is the enable, bits 31:17 are the base, and bit k (k = 1..15) set means address bit k+16 must equal window bit k+16. An enabled bank matches when every compared bit is equal. Address bits 16:0 and window bit 16 never affect the match.
- R4: A bank whose enable bit is clear never selects, unless R6 applies. This covers bank 0 or 1 holding a non-zero value with bit 0 clear.
- R5: When several enabled banks match, only the lowest-numbered bank is selected. The bank number is taken before the swap of R7.
- R6: When bank 0's window is all zeros, bank 0 is selected for every valid address. Otherwise, when bank 1's window is all zeros, bank 1 is selected for every valid address. This overrides all other matches.
- R7: The swap strap level present while reset is asserted is held after reset ends and ignores later strap changes. When it is 1, bank 0's decision drives cs_n bit 1 and bank 1's decision drives bit 0.
- R8: cs updates on the first rising edge at which bus_valid is high. It is all zeros after an edge where bus_valid is low or no bank is selected.
- R9: A bank 0 or 1 window of 0xFFFFFFFF matches only addresses 0xFFFE0000 to 0xFFFFFFFF.
- R10: At most one bit of cs is ever set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| boot_swap | input | 1 | Swap strap, captured during reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| bus_valid | input | 1 | Qualifies bus_addr |
| bus_addr | input | 32 | System bus address to decode |
| cs | output | 8 | Registered one-hot chip selects, active high |

## Verification
The bench targets the catch-all corner. If a zero bank 0 or 1 were gated by its enable bit, the out-of-reset access would miss entirely. If the catch-all did not outrank other banks, a later bank would appear. Overlapping enabled windows show whether priority is taken by bank number before the swap; a design that resolved it after the swap would light the wrong select when the strap is set. Partial compare masks, the top 128 KiB window of an all-ones register, and strap toggling after reset cover a mask shifted by one bit, a strap sampled live, and a decoder that leaks into the low 17 address bits.

// File: rtl/cs_bank_decoder.sv
module cs_bank_decoder #(
  parameter int NBANK      = 8,
  parameter int AW         = 32,
  parameter int RAW        = 12,
  parameter int REG_BASE   = 'h100,
  parameter int REG_STRIDE = 'h10,
  parameter int GRAN_LG    = 17
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           boot_swap,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [AW-1:0]  reg_wdata,
  output logic [AW-1:0]  reg_rdata,
  input  logic           bus_valid,
  input  logic [AW-1:0]  bus_addr,
  output logic [NBANK-1:0] cs
);
  localparam int TAGW      = AW - GRAN_LG;
  localparam int STRIDE_LG = $clog2(REG_STRIDE);
  localparam int IDXW      = $clog2(NBANK);

  logic [AW-1:0]    win_q [NBANK];
  logic             swap_q;
  logic [NBANK-1:0] cs_q, hit, pick, phys;

  logic [RAW-1:0] rel;
  logic           in_win;
  logic [IDXW-1:0] idx;

  assign rel    = reg_addr - RAW'(REG_BASE);
  assign in_win = (reg_addr >= RAW'(REG_BASE)) && (rel[STRIDE_LG-1:0] == '0)
                  && ((rel >> STRIDE_LG) < RAW'(NBANK));
  assign idx    = IDXW'(rel >> STRIDE_LG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBANK; i++) win_q[i] <= '0;
      swap_q <= boot_swap;
    end else if (reg_we && in_win) begin
      win_q[idx] <= reg_wdata;
    end
  end

  assign reg_rdata = in_win ? win_q[idx] : '0;

  for (genvar g = 0; g < NBANK; g++) begin : g_match
    assign hit[g] = win_q[g][0] &&
      (((bus_addr[AW-1:GRAN_LG] ^ win_q[g][AW-1:GRAN_LG]) & win_q[g][TAGW:1]) == '0);
  end

  always_comb begin
    logic found;
    pick  = '0;
    found = 1'b0;
    if (win_q[0] == '0) begin
      pick[0] = 1'b1;
    end else if (win_q[1] == '0) begin
      pick[1] = 1'b1;
    end else begin
      for (int i = 0; i < NBANK; i++) begin
        if (hit[i] && !found) begin
          pick[i] = 1'b1;
          found   = 1'b1;
        end
      end
    end
  end

  always_comb begin
    phys = pick;
    if (swap_q) begin
      phys[0] = pick[1];
      phys[1] = pick[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cs_q <= '0;
    else        cs_q <= bus_valid ? phys : '0;
  end

  assign cs = cs_q;

  a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_q));

  a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> (cs_q == '0));

  a_r7_swap_held: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(swap_q));

  a_r6_catch_all: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && win_q[0] == '0) |=> (cs_q == (swap_q ? NBANK'(2) : NBANK'(1))));

  a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && in_win) |=> (win_q[$past(idx)] == $past(reg_wdata)));
endmodule

// File: tb/cs_bank_decoder_tb.sv
module cs_bank_decoder_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        boot_swap = 0;
  logic        reg_we = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        bus_valid = 0;
  logic [31:0] bus_addr = '0;
  logic [7:0]  cs;

  int total = 0, bad = 0;
  logic [31:0] m [8];
  bit sw;

  always #5 clk = ~clk;

  cs_bank_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .boot_swap(boot_swap), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .cs(cs));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_cs(logic [31:0] a, bit s);
    logic [7:0] o = '0;
    logic [7:0] p;
    if (m[0] == 0) o[0] = 1;
    else if (m[1] == 0) o[1] = 1;
    else
      for (int i = 0; i < 8; i++)
        if (o == 0 && m[i][0] && (((a[31:17] ^ m[i][31:17]) & m[i][15:1]) == 0)) o[i] = 1;
    p = o;
    if (s) begin p[0] = o[1]; p[1] = o[0]; end
    return p;
  endfunction

  task automatic do_reset(bit strap);
    @(negedge clk);
    rst_n = 0; boot_swap = strap; bus_valid = 0; reg_we = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    boot_swap = ~strap;
    sw = strap;
    for (int i = 0; i < 8; i++) m[i] = '0;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 0;
    if (a >= 12'h100 && a[3:0] == 0 && a < 12'h180) m[(a - 12'h100) >> 4] = d;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    reg_addr = a; #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic probe(logic [31:0] a, bit v, string tag);
    @(negedge clk);
    bus_valid = v; bus_addr = a;
    @(posedge clk); #1;
    chk(tag, {24'd0, cs}, {24'd0, v ? exp_cs(a, sw) : 8'h00});
    bus_valid = 0;
  endtask

  task automatic rand_phase(int n, string tag);
    for (int k = 0; k < n; k++) begin
      int b = $urandom_range(0, 7);
      logic [31:0] d = $urandom;
      if (b < 2 && $urandom_range(0, 7) == 0) d = '0;
      else if (b < 2) d[0] = 1'b1;
      wr(12'h100 + 12'(b * 16), d);
      for (int j = 0; j < 3; j++) begin
        int t = $urandom_range(0, 7);
        logic [31:0] a = $urandom;
        if ($urandom_range(0, 1) == 1) a = (m[t] & 32'hFFFE0000) | (a & 32'h0001FFFF);
        probe(a, 1'b1, tag);
      end
    end
  endtask

  initial begin
    #1_500_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset(1'b0);
    for (int i = 0; i < 8; i++) rd(12'h100 + 12'(i * 16), 32'h0, "R1 reset value");
    chk("R8 reset cs", {24'd0, cs}, 32'h0);
    probe(32'h8765_4321, 1'b1, "R6 catch-all out of reset");
    probe(32'h8765_4321, 1'b0, "R8 idle");

    wr(12'h104, 32'hDEAD_BEEF);
    wr(12'h180, 32'h1234_5678);
    wr(12'h0F0, 32'hFFFF_FFFF);
    rd(12'h104, 32'h0, "R2 unmapped read");
    rd(12'h180, 32'h0, "R2 past last bank");
    for (int i = 0; i < 8; i++) rd(12'h100 + 12'(i * 16), 32'h0, "R2 banks untouched");
    probe(32'h0000_0000, 1'b1, "R2 still catch-all");

    wr(12'h100, 32'hFFFF_FFFF);
    wr(12'h110, 32'hFFFF_FFFF);
    rd(12'h110, 32'hFFFF_FFFF, "R1 readback");
    wr(12'h120, 32'h2000_0000 | (32'h7FFF << 1) | 1);
    probe(32'h2001_FFFF, 1'b1, "R3 full mask hit");
    probe(32'h2002_0000, 1'b1, "R3 full mask miss");
    probe(32'hFFFE_0000, 1'b1, "R9 top window hit");
    probe(32'hFFFD_FFFF, 1'b1, "R9 below top window");
    wr(12'h130, 32'h4000_0000 | (32'h7 << 13) | 1);
    probe(32'h5F00_1234, 1'b1, "R3 partial mask hit");
    probe(32'h6000_0000, 1'b1, "R3 partial mask miss");
    wr(12'h140, 32'h2000_0000 | (32'h7FFF << 1));
    probe(32'h2000_0040, 1'b1, "R5 bank2 over disabled bank4");
    wr(12'h140, 32'h2000_0000 | (32'h7FFF << 1) | 1);
    probe(32'h2000_0040, 1'b1, "R5 lowest enabled wins");
    chk("R5 bank2 selected", {24'd0, cs}, 32'h04);
    wr(12'h120, 32'h0000_0000);
    probe(32'h2000_0040, 1'b1, "R4 bank4 after bank2 disabled");
    wr(12'h140, 32'h2000_0000 | (32'h7FFF << 1));
    probe(32'h2000_0040, 1'b1, "R4 disabled bank4 no select");
    wr(12'h100, 32'h6000_0000 | (32'h7FFF << 1));
    probe(32'h6000_0000, 1'b1, "R4 bank0 nonzero disabled");
    chk("R4 nothing selected", {24'd0, cs}, 32'h0);
    wr(12'h110, 32'h0);
    probe(32'h5F00_0000, 1'b1, "R6 bank1 catch-all beats bank3");
    wr(12'h100, 32'h0);
    probe(32'h5F00_0000, 1'b1, "R6 bank0 beats bank1");

    rand_phase(250, "R3 R5 R10 random no swap");

    do_reset(1'b1);
    probe(32'h0000_1000, 1'b1, "R7 swapped catch-all");
    chk("R7 catch-all on cs1", {24'd0, cs}, 32'h02);
    wr(12'h100, 32'h2000_0000 | (32'h7FFF << 1) | 1);
    wr(12'h110, 32'h2000_0000 | (32'h7FFF << 1) | 1);
    probe(32'h2000_0000, 1'b1, "R7 R5 priority before swap");
    chk("R7 bank0 drives cs1", {24'd0, cs}, 32'h02);
    wr(12'h100, 32'hFFFF_FFFF);
    probe(32'h2000_0000, 1'b1, "R7 bank1 drives cs0");
    probe(32'hFFFF_0000, 1'b1, "R9 R7 top window swapped");
    rand_phase(200, "R7 R10 random swapped");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule